// File: doc/BRIEF.md
# Byte-Wide Configuration Loader With Self-Timed Serial Burst

This block sits between a microprocessor-style write bus and a chain of serially configured devices. Each configuration byte is written with a chip select and a write strobe. The block takes the byte on the trailing edge of the strobe and sends it out one bit at a time on a serial data line, most significant bit first. The clock that goes with the data is also brought out, so downstream slave devices can be clocked from it.

In the default asynchronous variant, the block makes its own clock: a burst of exactly eight pulses, timed from the system clock by a divider. A busy output holds off the writer until the burst is over, and any write made while busy is dropped. In the synchronous variant, chosen by a parameter, an external clock does the shifting instead. The block synchronizes that clock and moves one bit for each complete external pulse.

Top module: `cfg_periph_port`

## Requirements
- R1: A byte is captured only on the system clock edge that sees the write strobe go from 1 to 0 while chip select is 1. A strobe fall with chip select 0, or a strobe rise, captures nothing.
- R2: Busy goes to 1 on the cycle after the capture edge. In the asynchronous variant it stays 1 for exactly 16*DIV cycles.
- R3: A write made while busy is 1 is ignored. The captured byte keeps shifting unchanged, and no capture is left pending once busy clears.
- R4: In the asynchronous variant, each burst is exactly eight clock pulses. Counting j cycles after the capture edge, the clock output is 1 when floor(j/DIV) is odd and j < 16*DIV.
- R5: Bits leave most significant bit first, and a new bit appears on the falling edge of the clock. In the asynchronous variant, bit 7-k of the byte is on the serial output for 2k*DIV <= j < (2k+2)*DIV.
- R6: Outside a burst (busy 0), the clock output and the serial data output are both 0.
- R7: In the synchronous variant (SYNC_MODE=1), each bit moves on after one complete external pulse (a rise and then a fall) seen by a two-stage synchronizer. Busy clears after the eighth fall. The clock output follows the synchronized external clock while busy is 1.
- R8: After reset, busy, the clock output and the serial data output are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select, active high |
| wr_i | input | 1 | Write strobe; capture on its falling edge |
| data_i | input | DATA_W | Configuration byte from the bus |
| ext_cclk_i | input | 1 | External shift clock (synchronous variant only) |
| busy_o | output | 1 | 1 while a byte is being serialized |
| dout_o | output | 1 | Serial configuration data, MSB first |
| cclk_o | output | 1 | Configuration clock for the burst and downstream slaves |

## Verification
Counting from the capture edge, the asynchronous results follow a fixed cycle schedule. Busy rises one cycle after the edge and stays up for 16*DIV cycles. The clock flips every DIV cycles, and the data bit changes every 2*DIV cycles. The bench samples busy, clock and data on every falling edge of the system clock and compares each with a value computed from that cycle count. This is done for all 256 byte values, plus a few cycles of idle afterwards. In the synchronous variant the synchronizer and the edge detector add a few cycles of latency, so the bench waits four cycles after each change of the external clock before it compares.

// File: rtl/cfg_periph_pkg.sv
package cfg_periph_pkg;
  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } cclk_phase_e;
endpackage

// File: rtl/cfg_wr_detect.sv
module cfg_wr_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic wr_i,
  output logic wr_fall_o
);
  logic wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_q <= 1'b0;
    else         wr_q <= wr_i;
  end

  assign wr_fall_o = wr_q & ~wr_i & cs_i;
endmodule

// File: rtl/cfg_burst_clk.sv
module cfg_burst_clk
  import cfg_periph_pkg::*;
#(
  parameter int unsigned DIV       = 4,
  parameter bit          SYNC_MODE = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic run_i,
  input  logic ext_cclk_i,
  output logic cclk_o,
  output logic pulse_done_o
);
  localparam int unsigned DW = (DIV > 1) ? $clog2(DIV) : 1;

  if (SYNC_MODE) begin : g_sync
    logic [2:0] sync_q;
    logic       seen_rise;
    logic       rise, fall;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q <= '0;
      else         sync_q <= {sync_q[1:0], ext_cclk_i};
    end

    assign rise = sync_q[1] & ~sync_q[2];
    assign fall = ~sync_q[1] & sync_q[2];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  seen_rise <= 1'b0;
      else if (start_i)             seen_rise <= 1'b0;
      else if (run_i && rise)       seen_rise <= 1'b1;
      else if (pulse_done_o)        seen_rise <= 1'b0;
    end

    assign pulse_done_o = run_i & fall & seen_rise;
    assign cclk_o       = sync_q[1] & run_i;
  end else begin : g_async
    logic          unused_ext;
    logic [DW-1:0] cnt;
    cclk_phase_e   ph;

    assign unused_ext = ext_cclk_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt <= '0;
        ph  <= PH_LOW;
      end else if (start_i) begin
        cnt <= DW'(DIV - 1);
        ph  <= PH_LOW;
      end else if (run_i) begin
        if (cnt != '0) begin
          cnt <= cnt - DW'(1);
        end else begin
          cnt <= DW'(DIV - 1);
          ph  <= (ph == PH_LOW) ? PH_HIGH : PH_LOW;
        end
      end else begin
        ph <= PH_LOW;
      end
    end

    assign pulse_done_o = run_i & (ph == PH_HIGH) & (cnt == '0);
    assign cclk_o       = (ph == PH_HIGH);
  end
endmodule

// File: rtl/cfg_byte_shifter.sv
module cfg_byte_shifter #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              shift_i,
  output logic              busy_o,
  output logic              dout_o
);
  localparam int unsigned CW = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  logic [DATA_W-1:0] sreg;
  logic [CW-1:0]     bit_cnt;
  logic              last_bit;

  assign last_bit = (bit_cnt == CW'(DATA_W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg    <= '0;
      bit_cnt <= '0;
      busy_o  <= 1'b0;
    end else if (load_i) begin
      sreg    <= data_i;
      bit_cnt <= '0;
      busy_o  <= 1'b1;
    end else if (shift_i && busy_o) begin
      sreg <= {sreg[DATA_W-2:0], 1'b0};
      if (last_bit) busy_o  <= 1'b0;
      else          bit_cnt <= bit_cnt + CW'(1);
    end
  end

  assign dout_o = sreg[DATA_W-1];
endmodule

// File: rtl/cfg_periph_port.sv
module cfg_periph_port #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned DIV       = 4,
  parameter bit          SYNC_MODE = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ext_cclk_i,
  output logic              busy_o,
  output logic              dout_o,
  output logic              cclk_o
);
  logic wr_fall;
  logic cap;
  logic pulse_done;

  cfg_wr_detect u_wr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_i      (cs_i),
    .wr_i      (wr_i),
    .wr_fall_o (wr_fall)
  );

  // writes during a burst are dropped, not queued
  assign cap = wr_fall & ~busy_o;

  cfg_burst_clk #(
    .DIV       (DIV),
    .SYNC_MODE (SYNC_MODE)
  ) u_clk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (cap),
    .run_i        (busy_o),
    .ext_cclk_i   (ext_cclk_i),
    .cclk_o       (cclk_o),
    .pulse_done_o (pulse_done)
  );

  cfg_byte_shifter #(
    .DATA_W (DATA_W)
  ) u_sh (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (cap),
    .data_i  (data_i),
    .shift_i (pulse_done),
    .busy_o  (busy_o),
    .dout_o  (dout_o)
  );
endmodule

// File: rtl/cfg_periph_port_chk.sv
module cfg_periph_port_chk #(
  parameter int unsigned DATA_W    = 8,
  parameter bit          SYNC_MODE = 1'b0
) (
  input logic clk_i,
  input logic rst_ni,
  input logic cap_i,
  input logic busy_i,
  input logic dout_i,
  input logic cclk_i
);
  logic [7:0] n_rise;
  logic       cclk_q;
  logic       busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_rise <= '0;
      cclk_q <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      cclk_q <= cclk_i;
      busy_q <= busy_i;
      if (cap_i)                n_rise <= '0;
      else if (cclk_i && !cclk_q) n_rise <= n_rise + 8'd1;
    end
  end

  p_busy_after_cap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> busy_i);

  p_idle_clk_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !cclk_i);

  p_idle_dout_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !dout_i);

  if (!SYNC_MODE) begin : g_async_chk
    p_dout_moves_on_fall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_i && $past(busy_i) && !$fell(cclk_i)) |-> $stable(dout_i));

    p_eight_pulses_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_q && !busy_i) |-> (n_rise == 8'(DATA_W)));
  end
endmodule

bind cfg_periph_port cfg_periph_port_chk #(
  .DATA_W    (DATA_W),
  .SYNC_MODE (SYNC_MODE)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .cap_i  (cap),
  .busy_i (busy_o),
  .dout_i (dout_o),
  .cclk_i (cclk_o)
);

// File: tb/tb_cfg_periph_port.sv
`timescale 1ns/1ps
module tb_cfg_periph_port;
  localparam int DIV = 4;
  localparam int BURST = 16 * DIV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, wr = 1'b0;
  logic [7:0] data = '0;
  logic busy, dout, cclk;
  logic cs_s = 1'b0, wr_s = 1'b0, ext_s = 1'b0;
  logic [7:0] data_s = '0;
  logic busy_s, dout_s, cclk_s;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cfg_periph_port #(.DATA_W(8), .DIV(DIV), .SYNC_MODE(1'b0)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .wr_i(wr), .data_i(data),
    .ext_cclk_i(1'b0), .busy_o(busy), .dout_o(dout), .cclk_o(cclk));

  cfg_periph_port #(.DATA_W(8), .DIV(DIV), .SYNC_MODE(1'b1)) dut_sync (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs_s), .wr_i(wr_s), .data_i(data_s),
    .ext_cclk_i(ext_s), .busy_o(busy_s), .dout_o(dout_s), .cclk_o(cclk_s));

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // ends at the falling edge right after the capture edge (j = 0)
  task automatic wr_async(input logic [7:0] b, input logic sel);
    @(negedge clk); cs = sel; wr = 1'b1; data = b;
    @(negedge clk); wr = 1'b0;
    @(negedge clk); cs = 1'b0;
  endtask

  task automatic wr_sync(input logic [7:0] b);
    @(negedge clk); cs_s = 1'b1; wr_s = 1'b1; data_s = b;
    @(negedge clk); wr_s = 1'b0;
    @(negedge clk); cs_s = 1'b0;
  endtask

  task automatic check_burst(input logic [7:0] b, input bit intrude);
    for (int j = 0; j < BURST + 3; j++) begin
      logic e_busy, e_clk, e_dout;
      e_busy = (j < BURST);
      e_clk  = e_busy && (((j / DIV) % 2) == 1);
      e_dout = e_busy ? b[7 - j / (2 * DIV)] : 1'b0;
      chk(intrude ? "R3" : "R2", "busy", busy, e_busy);
      chk(e_busy ? "R4" : "R6", "cclk", cclk, e_clk);
      chk(e_busy ? (intrude ? "R3" : "R5") : "R6", "dout", dout, e_dout);
      if (intrude) begin
        if (j == 5) begin cs = 1'b1; wr = 1'b1; data = ~b; end
        if (j == 6) wr = 1'b0;
        if (j == 7) cs = 1'b0;
      end
      @(negedge clk);
    end
  endtask

  task automatic check_sync(input logic [7:0] b);
    chk("R7", "sync busy start", busy_s, 1'b1);
    chk("R7", "sync dout msb", dout_s, b[7]);
    chk("R7", "sync cclk start", cclk_s, 1'b0);
    for (int k = 1; k <= 8; k++) begin
      ext_s = 1'b1;
      repeat (4) @(negedge clk);
      chk("R7", "sync cclk high", cclk_s, 1'b1);
      chk("R7", "sync dout held", dout_s, b[8 - k]);
      ext_s = 1'b0;
      repeat (4) @(negedge clk);
      chk("R7", "sync busy", busy_s, k < 8);
      chk("R7", "sync dout", dout_s, (k < 8) ? b[7 - (k % 8)] : 1'b0);
      chk("R7", "sync cclk low", cclk_s, 1'b0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog run did not complete");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R8", "reset busy", busy, 1'b0);
    chk("R8", "reset cclk", cclk, 1'b0);
    chk("R8", "reset dout", dout, 1'b0);
    chk("R8", "reset sync busy", busy_s, 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1: strobe fall with chip select low
    wr_async(8'hFF, 1'b0);
    for (int j = 0; j < 6; j++) begin
      chk("R1", "no capture cs low", busy, 1'b0);
      chk("R6", "idle dout", dout, 1'b0);
      @(negedge clk);
    end

    // R1: strobe rise with chip select high
    cs = 1'b1; data = 8'hAA; wr = 1'b1;
    for (int j = 0; j < 6; j++) begin
      @(negedge clk);
      chk("R1", "no capture on rise", busy, 1'b0);
    end
    cs = 1'b0; wr = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1", "no capture cs low fall", busy, 1'b0);

    // full sweep of byte values
    for (int v = 0; v < 256; v++) begin
      wr_async(8'(v), 1'b1);
      check_burst(8'(v), (v == 8'hA5) || (v == 8'h3C) || (v == 8'h00));
    end

    // synchronous variant
    foreach (data_s[i]) begin end
    wr_sync(8'h96); check_sync(8'h96);
    wr_sync(8'h01); check_sync(8'h01);
    wr_sync(8'h80); check_sync(8'h80);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule